// File: doc/BRIEF.md
# Planar Display Memory Datapath

This block connects a byte-wide CPU data path to a display memory that is 32 bits wide and split into four byte-wide bit planes. When the CPU writes, the block copies the CPU byte to all four planes. It combines each copy with the matching byte held in the plane latches, using a selectable logical operation. It then drives a per-plane write enable that a plane-enable mask can suppress. When the CPU reads, all four plane bytes are captured in the latches, and one of them is returned under a plane select.

On the screen refresh side, the block captures a 32-bit fetch. In graphics mode it turns the fetch into eight 4-bit pixels, one per dot-clock enable. Pixel k takes bit 7-k of every plane, and plane 3 gives the most significant pixel bit. After the eighth pixel the block pulses a request for the next fetch. In text mode, plane 0 is presented as the character byte and plane 1 as the attribute byte, side by side and with no serialisation. Memory timing, addressing and bus decoding belong to the surrounding logic.

Top module: `plane_datapath`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `mem_we`, `pix_valid`, `text_valid`, `fetch_req` and `cpu_rdata` are all zero.
- R2: A cycle with `cpu_rd_load` high captures `mem_rdata` into four plane latches. Plane p is bits [8p+7:8p]. One cycle later `cpu_rdata` shows plane `rd_plane_sel`.
- R3: With `cpu_rd_load` low, a change of `rd_plane_sel` shows the matching latched byte one cycle later. The latches keep their contents.
- R4: One cycle after `cpu_wr`, byte p of `mem_wdata` equals f(`cpu_wdata`, latch p). `op_sel` picks f: 0 passes the CPU byte, 1 is AND, 2 is OR, 3 is XOR.
- R5: For one cycle after `cpu_wr`, `mem_we` equals `plane_en`, where bit p set allows writes to plane p. In every other cycle `mem_we` is zero.
- R6: When `cpu_wr` and `cpu_rd_load` are high in the same cycle, the write combines with the latch contents held before that cycle.
- R7: In graphics mode (`text_mode` low) a `fetch_load` captures `fetch_data`. The k-th cycle afterwards that has `dot_en` high gives, one cycle later, `pix_valid` high and `pix_out` = {p3[7-k], p2[7-k], p1[7-k], p0[7-k]}.
- R8: Cycles with `dot_en` low produce no pixel and leave the pixel order unchanged.
- R9: `fetch_req` pulses for one cycle together with the eighth pixel. Further `dot_en` cycles produce no pixel until the next `fetch_load`.
- R10: A `fetch_load` with `text_mode` high gives `char_out` = plane 0, `attr_out` = plane 1 and a one-cycle `text_valid` one cycle later. No pixels follow from it.
- R11: A `fetch_load` while pixels are still pending restarts the sequence with the new data. A `dot_en` in that same cycle emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| op_sel | input | 2 | Logical operation select |
| plane_en | input | 4 | Per-plane write allow mask |
| cpu_rd_load | input | 1 | Capture memory read data into plane latches |
| mem_rdata | input | 32 | Four-plane memory read data |
| rd_plane_sel | input | 2 | Plane returned to the CPU |
| cpu_rdata | output | 8 | Selected latched plane byte |
| mem_wdata | output | 32 | Four-plane write data |
| mem_we | output | 4 | Per-plane write enable |
| fetch_load | input | 1 | Refresh fetch valid |
| fetch_data | input | 32 | Refresh fetch data |
| text_mode | input | 1 | 1 selects text, 0 selects graphics |
| dot_en | input | 1 | Dot-clock enable |
| pix_out | output | 4 | Serial pixel |
| pix_valid | output | 1 | Pixel valid |
| char_out | output | 8 | Text character byte |
| attr_out | output | 8 | Text attribute byte |
| text_valid | output | 1 | Text bytes valid |
| fetch_req | output | 1 | Request for the next refresh fetch |

## Verification
Every result is a register one clock edge behind the stimulus that causes it. This covers the read byte, the write data and enables, each pixel, the text bytes and the fetch request. The bench changes inputs on the falling edge and compares outputs at the next falling edge, so exactly one rising edge lies between stimulus and check. Gap cycles with `dot_en` low, and the cycle just after a write, are also compared at that same one-edge distance, to confirm that nothing is emitted there.

// File: rtl/plane_dp_pkg.sv
package plane_dp_pkg;
  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2,
    OP_XOR  = 2'd3
  } wr_op_e;
endpackage

// File: rtl/plane_latch.sv
module plane_latch #(
  parameter int NPL = 4,
  parameter int PW  = 8,
  localparam int SELW = $clog2(NPL),
  localparam int BW   = NPL * PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BW-1:0]   rdata_in,
  input  logic [SELW-1:0] sel,
  output logic [BW-1:0]   latch_q,
  output logic [PW-1:0]   byte_q
);
  logic [BW-1:0] src;
  assign src = load ? rdata_in : latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      byte_q  <= '0;
    end else begin
      if (load) latch_q <= rdata_in;
      byte_q <= src[sel*PW +: PW];
    end
  end

  // R3: without a load the plane latches keep their contents
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(latch_q));
endmodule

// File: rtl/plane_alu.sv
module plane_alu
  import plane_dp_pkg::*;
#(
  parameter int NPL = 4,
  parameter int PW  = 8,
  localparam int BW = NPL * PW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  wr_op_e         op,
  input  logic [PW-1:0]  cpu_byte,
  input  logic [BW-1:0]  latch_q,
  input  logic [NPL-1:0] plane_en,
  output logic [BW-1:0]  wdata_q,
  output logic [NPL-1:0] we_q
);
  logic [BW-1:0] res;

  for (genvar p = 0; p < NPL; p++) begin : g_plane
    logic [PW-1:0] lb;
    assign lb = latch_q[p*PW +: PW];
    always_comb begin
      unique case (op)
        OP_AND:  res[p*PW +: PW] = cpu_byte & lb;
        OP_OR:   res[p*PW +: PW] = cpu_byte | lb;
        OP_XOR:  res[p*PW +: PW] = cpu_byte ^ lb;
        default: res[p*PW +: PW] = cpu_byte;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q <= '0;
      we_q    <= '0;
    end else begin
      we_q <= wr ? plane_en : '0;
      if (wr) wdata_q <= res;
    end
  end

  // R5: no enable without a write request
  p_we_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (we_q == '0));
  // R5: an enabled plane must have been allowed by the mask
  p_we_masked_r5: assert property (@(posedge clk) disable iff (rst)
    wr |=> ((we_q & ~$past(plane_en)) == '0));
endmodule

// File: rtl/pix_serial.sv
module pix_serial #(
  parameter int NPL = 4,
  parameter int PW  = 8,
  localparam int BW = NPL * PW,
  localparam int CW = $clog2(PW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [BW-1:0]  fetch,
  input  logic           text_mode,
  input  logic           dot_en,
  output logic [NPL-1:0] pix,
  output logic           pix_valid,
  output logic [PW-1:0]  chr,
  output logic [PW-1:0]  attr,
  output logic           text_valid,
  output logic           req
);
  logic [BW-1:0]  shreg, shift_d;
  logic [NPL-1:0] pix_next;
  logic [CW-1:0]  cnt;

  for (genvar p = 0; p < NPL; p++) begin : g_pl
    assign pix_next[p] = shreg[p*PW + PW - 1];
    assign shift_d[p*PW +: PW] = {shreg[p*PW +: PW-1], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0; cnt <= '0; pix <= '0; pix_valid <= 1'b0;
      chr <= '0; attr <= '0; text_valid <= 1'b0; req <= 1'b0;
    end else begin
      pix_valid  <= 1'b0;
      text_valid <= 1'b0;
      req        <= 1'b0;
      if (load) begin
        shreg <= fetch;
        if (text_mode) begin
          chr        <= fetch[PW-1:0];
          attr       <= fetch[2*PW-1:PW];
          text_valid <= 1'b1;
          cnt        <= '0;
        end else begin
          cnt <= CW'(PW);
        end
      end else if (dot_en && cnt != '0) begin
        pix       <= pix_next;
        pix_valid <= 1'b1;
        shreg     <= shift_d;
        cnt       <= cnt - 1'b1;
        req       <= (cnt == CW'(1));
      end
    end
  end

  // R9: the request only accompanies an emitted pixel
  p_req_pix_r9: assert property (@(posedge clk) disable iff (rst)
    req |-> pix_valid);
  // R8: a pixel needs a dot enable in the previous cycle
  p_pix_dot_r8: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(dot_en));
  // R10: text and pixel outputs never valid together
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(pix_valid && text_valid));
  // R11: a load cycle never emits a pixel
  p_load_nopix_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> !pix_valid);
endmodule

// File: rtl/plane_datapath.sv
module plane_datapath
  import plane_dp_pkg::*;
#(
  parameter int NPL = 4,
  parameter int PW  = 8,
  localparam int SELW = $clog2(NPL),
  localparam int BW   = NPL * PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_wr,
  input  logic [PW-1:0]   cpu_wdata,
  input  logic [1:0]      op_sel,
  input  logic [NPL-1:0]  plane_en,
  input  logic            cpu_rd_load,
  input  logic [BW-1:0]   mem_rdata,
  input  logic [SELW-1:0] rd_plane_sel,
  output logic [PW-1:0]   cpu_rdata,
  output logic [BW-1:0]   mem_wdata,
  output logic [NPL-1:0]  mem_we,
  input  logic            fetch_load,
  input  logic [BW-1:0]   fetch_data,
  input  logic            text_mode,
  input  logic            dot_en,
  output logic [NPL-1:0]  pix_out,
  output logic            pix_valid,
  output logic [PW-1:0]   char_out,
  output logic [PW-1:0]   attr_out,
  output logic            text_valid,
  output logic            fetch_req
);
  logic [BW-1:0] latch_q;

  plane_latch #(.NPL(NPL), .PW(PW)) u_latch (
    .clk(clk), .rst(rst), .load(cpu_rd_load), .rdata_in(mem_rdata),
    .sel(rd_plane_sel), .latch_q(latch_q), .byte_q(cpu_rdata)
  );

  plane_alu #(.NPL(NPL), .PW(PW)) u_alu (
    .clk(clk), .rst(rst), .wr(cpu_wr), .op(wr_op_e'(op_sel)),
    .cpu_byte(cpu_wdata), .latch_q(latch_q), .plane_en(plane_en),
    .wdata_q(mem_wdata), .we_q(mem_we)
  );

  pix_serial #(.NPL(NPL), .PW(PW)) u_ser (
    .clk(clk), .rst(rst), .load(fetch_load), .fetch(fetch_data),
    .text_mode(text_mode), .dot_en(dot_en), .pix(pix_out),
    .pix_valid(pix_valid), .chr(char_out), .attr(attr_out),
    .text_valid(text_valid), .req(fetch_req)
  );
endmodule

// File: tb/plane_datapath_tb_top.sv
`timescale 1ns/1ps
module plane_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 0, cpu_rd_load = 0, fetch_load = 0, text_mode = 0, dot_en = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [1:0]  op_sel = 0, rd_plane_sel = 0;
  logic [3:0]  plane_en = 0;
  logic [31:0] mem_rdata = 0, fetch_data = 0;
  logic [7:0]  cpu_rdata, char_out, attr_out;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_we, pix_out;
  logic        pix_valid, text_valid, fetch_req;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_latch = 0;

  always #2.5 clk = ~clk;

  plane_datapath dut_i (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .op_sel(op_sel),
    .plane_en(plane_en), .cpu_rd_load(cpu_rd_load), .mem_rdata(mem_rdata),
    .rd_plane_sel(rd_plane_sel), .cpu_rdata(cpu_rdata), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .fetch_load(fetch_load), .fetch_data(fetch_data),
    .text_mode(text_mode), .dot_en(dot_en), .pix_out(pix_out), .pix_valid(pix_valid),
    .char_out(char_out), .attr_out(attr_out), .text_valid(text_valid),
    .fetch_req(fetch_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_wr(input logic [7:0] b, input logic [1:0] op, input logic [31:0] lat);
    logic [31:0] r;
    for (int p = 0; p < 4; p++) begin
      case (op)
        2'd1: r[p*8 +: 8] = b & lat[p*8 +: 8];
        2'd2: r[p*8 +: 8] = b | lat[p*8 +: 8];
        2'd3: r[p*8 +: 8] = b ^ lat[p*8 +: 8];
        default: r[p*8 +: 8] = b;
      endcase
    end
    return r;
  endfunction

  function automatic logic [3:0] f_pix(input logic [31:0] d, input int k);
    logic [3:0] r;
    for (int p = 0; p < 4; p++) r[p] = d[p*8 + 7 - k];
    return r;
  endfunction

  task automatic do_read(input logic [31:0] d, input logic [1:0] s);
    @(negedge clk); cpu_rd_load = 1; mem_rdata = d; rd_plane_sel = s;
    @(negedge clk); cpu_rd_load = 0; m_latch = d;
    chk(cpu_rdata == d[s*8 +: 8], "R2 read byte", cpu_rdata, d[s*8 +: 8]);
  endtask

  task automatic do_sel(input logic [1:0] s);
    @(negedge clk); rd_plane_sel = s; mem_rdata = $urandom;
    @(negedge clk);
    chk(cpu_rdata == m_latch[s*8 +: 8], "R3 select without load", cpu_rdata, m_latch[s*8 +: 8]);
  endtask

  task automatic do_write(input logic [7:0] b, input logic [1:0] op, input logic [3:0] en, input bit with_rd);
    logic [31:0] exp, nd;
    exp = f_wr(b, op, m_latch);
    nd = $urandom;
    @(negedge clk); cpu_wr = 1; cpu_wdata = b; op_sel = op; plane_en = en;
    if (with_rd) begin cpu_rd_load = 1; mem_rdata = nd; end
    @(negedge clk); cpu_wr = 0; cpu_rd_load = 0;
    if (with_rd) m_latch = nd;
    chk(mem_wdata == exp, with_rd ? "R6 write uses old latch" : "R4 write data", mem_wdata, exp);
    chk(mem_we == en, "R5 write enables", {28'd0, mem_we}, {28'd0, en});
    @(negedge clk);
    chk(mem_we == 4'd0, "R5 enables drop", {28'd0, mem_we}, 32'd0);
  endtask

  task automatic do_gfx(input logic [31:0] d, input int maxgap);
    @(negedge clk); fetch_load = 1; fetch_data = d; text_mode = 0; dot_en = 0;
    @(negedge clk); fetch_load = 0;
    for (int k = 0; k < 8; k++) begin
      int g;
      g = $urandom_range(maxgap, 0);
      for (int i = 0; i < g; i++) begin
        @(negedge clk);
        chk(!pix_valid, "R8 no pixel in gap", {31'd0, pix_valid}, 32'd0);
      end
      dot_en = 1;
      @(negedge clk); dot_en = 0;
      chk(pix_valid && pix_out == f_pix(d, k), "R7 pixel value",
          {27'd0, pix_valid, pix_out}, {27'd1, f_pix(d, k)});
      chk(fetch_req == (k == 7), "R9 fetch request", {31'd0, fetch_req}, {31'd0, k == 7});
    end
    dot_en = 1;
    @(negedge clk); dot_en = 0;
    chk(!pix_valid && !fetch_req, "R9 exhausted", {30'd0, pix_valid, fetch_req}, 32'd0);
  endtask

  task automatic do_text(input logic [31:0] d);
    @(negedge clk); fetch_load = 1; fetch_data = d; text_mode = 1; dot_en = 1;
    @(negedge clk); fetch_load = 0;
    chk(text_valid && char_out == d[7:0] && attr_out == d[15:8], "R10 text bytes",
        {15'd0, text_valid, char_out, attr_out}, {15'd1, d[7:0], d[15:8]});
    @(negedge clk); dot_en = 0;
    chk(!pix_valid && !text_valid, "R10 no pixels in text", {30'd0, pix_valid, text_valid}, 32'd0);
    text_mode = 0;
  endtask

  task automatic do_restart(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); fetch_load = 1; fetch_data = a; text_mode = 0;
    @(negedge clk); fetch_load = 0;
    repeat (3) begin dot_en = 1; @(negedge clk); dot_en = 0; end
    fetch_load = 1; fetch_data = b; dot_en = 1;
    @(negedge clk); fetch_load = 0; dot_en = 0;
    chk(!pix_valid, "R11 no pixel on reload", {31'd0, pix_valid}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      dot_en = 1;
      @(negedge clk); dot_en = 0;
      chk(pix_valid && pix_out == f_pix(b, k), "R11 restarted pixel",
          {27'd0, pix_valid, pix_out}, {27'd1, f_pix(b, k)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(mem_we == 0 && !pix_valid && !text_valid && !fetch_req && cpu_rdata == 0,
        "R1 reset state", {mem_we, pix_valid, text_valid, fetch_req, cpu_rdata}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk(mem_we == 0 && !pix_valid && !text_valid && !fetch_req && cpu_rdata == 0,
        "R1 after reset", {mem_we, pix_valid, text_valid, fetch_req, cpu_rdata}, 32'd0);

    do_read(32'hA1B2C3D4, 2'd3);
    for (int s = 0; s < 4; s++) do_sel(2'(s));
    for (int op = 0; op < 4; op++) do_write(8'h5A, 2'(op), 4'b1010, 0);
    do_write(8'hFF, 2'd0, 4'b0000, 0);
    do_write(8'h3C, 2'd3, 4'b1111, 1);
    do_gfx(32'h80_40_20_01, 0);
    do_gfx(32'hFF_00_AA_55, 3);
    do_text(32'h1234_7E41);
    do_restart(32'hDEADBEEF, 32'h0F_F0_33_CC);

    for (int it = 0; it < 60; it++) begin
      case ($urandom_range(4, 0))
        0: do_read($urandom, 2'($urandom_range(3, 0)));
        1: do_sel(2'($urandom_range(3, 0)));
        2: do_write(8'($urandom), 2'($urandom_range(3, 0)), 4'($urandom), bit'($urandom_range(1, 0)));
        3: do_gfx($urandom, 2);
        default: do_text($urandom);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule